// File: doc/BRIEF.md
# Power-of-Two Weight Shift Accumulator

This processing element forms the product of a signed 8-bit activation and a 4-bit power-of-two weight code without a multiplier. The code is decoded into a sign and an exponent. The activation is sign-extended and shifted left by the exponent. The shifted value is then negated or passed through, depending on the sign. The product is produced combinationally in the same cycle and feeds a single adder into a signed 32-bit accumulator.

A caller streams activation and weight pairs with a valid strobe. Raising the clear input together with valid starts a new dot product: the accumulator loads the current product instead of adding it. When valid is low the accumulator holds its value. The code has no zero level, so every legal code scales the activation by a nonzero factor.

Top module: `pot_shift_mac`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `acc_o` reads 0.
- R2: Weight code bit 3 is the sign (0 means positive, 1 means negative). Bits 2:0 hold the exponent s (0 to 7). The weight is +2^s or -2^s and is never zero.
- R3: For every one of the 256 activations and 16 codes, the product equals activation × weight exactly, including -128 with weight -128 (giving +16384).
- R4: With `valid_i` high and `clear_i` low, the accumulator after the clock edge equals its previous value plus the sign-extended product.
- R5: With `valid_i` low, the accumulator keeps its value whatever `act_i`, `wcode_i` and `clear_i` carry, including `clear_i` high.
- R6: With `valid_i` and `clear_i` both high, the accumulator after the edge equals the current product, and the earlier sum is discarded.
- R7: A beat sampled at a clock edge is visible on `acc_o` right after that same edge. There is no extra pipeline stage.
- R8: The accumulator is a 32-bit two's-complement value. Sums of positive and negative products cross zero correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 8 | Signed activation |
| wcode_i | input | 4 | Weight code: sign in bit 3, exponent in bits 2:0 |
| valid_i | input | 1 | Beat strobe; the accumulator updates only when it is high |
| clear_i | input | 1 | With valid, load the product instead of adding it |
| acc_o | output | 32 | Signed running sum |

## Verification
The assertions assume that `valid_i` and `clear_i` are driven to known levels in every cycle after reset is released. They also assume that `act_i` and `wcode_i` are stable around each rising edge. The product checks assume a nonzero activation must give a nonzero product whose sign is the activation sign XOR the weight sign. The bench changes every input only at the falling edge. It keeps `valid_i` low throughout reset, and it uses only the 4-bit code space, which is fully legal because no code is reserved.

// File: rtl/pot_mac_pkg.sv
package pot_mac_pkg;

   localparam int unsigned ACT_W_DEF  = 8;
   localparam int unsigned CODE_W_DEF = 4;
   localparam int unsigned ACC_W_DEF  = 32;

   typedef enum logic {
      WSIGN_POS = 1'b0,
      WSIGN_NEG = 1'b1
   } wsign_e;

   typedef enum logic {
      SHIFT_DIRECT = 1'b0,
      SHIFT_LOG    = 1'b1
   } shift_impl_e;

endpackage

// File: rtl/pot_code_decode.sv
module pot_code_decode
   import pot_mac_pkg::*;
#(
   parameter int unsigned CODE_W  = CODE_W_DEF,
   localparam int unsigned SHIFT_W = CODE_W - 1
) (
   input  logic [CODE_W-1:0]  code_i,
   output wsign_e             sign_o,
   output logic [SHIFT_W-1:0] shamt_o
);

   if (CODE_W < 2) begin : g_bad_code
      $error("pot_code_decode: CODE_W must be at least 2");
   end

   assign sign_o  = wsign_e'(code_i[CODE_W-1]);
   assign shamt_o = code_i[SHIFT_W-1:0];

endmodule

// File: rtl/pot_shift_product.sv
module pot_shift_product
   import pot_mac_pkg::*;
#(
   parameter int unsigned ACT_W      = ACT_W_DEF,
   parameter int unsigned SHIFT_W    = CODE_W_DEF - 1,
   parameter shift_impl_e SHIFT_IMPL = SHIFT_LOG,
   localparam int unsigned MAX_SH    = (1 << SHIFT_W) - 1,
   localparam int unsigned PROD_W    = ACT_W + MAX_SH + 1
) (
   input  logic [ACT_W-1:0]   act_i,
   input  wsign_e             sign_i,
   input  logic [SHIFT_W-1:0] shamt_i,
   output logic [PROD_W-1:0]  prod_o
);

   if (ACT_W < 2) begin : g_bad_act
      $error("pot_shift_product: ACT_W must be at least 2");
   end

   logic [PROD_W-1:0] act_ext;
   logic [PROD_W-1:0] mag;

   assign act_ext = {{(PROD_W-ACT_W){act_i[ACT_W-1]}}, act_i};

   if (SHIFT_IMPL == SHIFT_LOG) begin : g_log
      logic [PROD_W-1:0] stage [SHIFT_W+1];
      assign stage[0] = act_ext;
      for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
         assign stage[k+1] = shamt_i[k] ? (stage[k] << (1 << k)) : stage[k];
      end
      assign mag = stage[SHIFT_W];
   end else begin : g_direct
      assign mag = act_ext << shamt_i;
   end

   assign prod_o = (sign_i == WSIGN_NEG) ? (~mag + 1'b1) : mag;

   always_comb begin
      if (act_i != '0) begin
         // R2
         nonzero_prod_chk: assert (prod_o != '0);
         // R3
         prod_sign_chk: assert (prod_o[PROD_W-1] == (act_i[ACT_W-1] ^ sign_i));
      end
   end

endmodule

// File: rtl/pot_accum.sv
module pot_accum #(
   parameter int unsigned PROD_W = 16,
   parameter int unsigned ACC_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [PROD_W-1:0] prod_i,
   input  logic              valid_i,
   input  logic              clear_i,
   output logic [ACC_W-1:0]  acc_o
);

   if (ACC_W < PROD_W) begin : g_bad_acc
      $error("pot_accum: ACC_W must not be narrower than PROD_W");
   end

   logic [ACC_W-1:0] prod_ext;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] base;

   assign prod_ext = {{(ACC_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
   assign base     = clear_i ? '0 : acc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (valid_i) begin
         acc_q <= base + prod_ext;
      end
   end

   assign acc_o = acc_q;

   // R5
   hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(acc_q));
   // R6
   clear_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && clear_i) |=> (acc_q == $past(prod_ext)));
   // R4
   accum_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !clear_i) |=> ((acc_q - $past(acc_q)) == $past(prod_ext)));
   // R1
   reset_zero_chk: assert property (@(posedge clk_i)
      !rst_ni |=> (acc_q == '0));

endmodule

// File: rtl/pot_shift_mac.sv
module pot_shift_mac
   import pot_mac_pkg::*;
#(
   parameter int unsigned ACT_W      = ACT_W_DEF,
   parameter int unsigned CODE_W     = CODE_W_DEF,
   parameter int unsigned ACC_W      = ACC_W_DEF,
   parameter shift_impl_e SHIFT_IMPL = SHIFT_LOG,
   localparam int unsigned SHIFT_W   = CODE_W - 1,
   localparam int unsigned PROD_W    = ACT_W + ((1 << SHIFT_W) - 1) + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ACT_W-1:0]  act_i,
   input  logic [CODE_W-1:0] wcode_i,
   input  logic              valid_i,
   input  logic              clear_i,
   output logic [ACC_W-1:0]  acc_o
);

   wsign_e             wsign;
   logic [SHIFT_W-1:0] shamt;
   logic [PROD_W-1:0]  prod;

   pot_code_decode #(.CODE_W(CODE_W)) u_dec (
      .code_i  (wcode_i),
      .sign_o  (wsign),
      .shamt_o (shamt)
   );

   pot_shift_product #(
      .ACT_W      (ACT_W),
      .SHIFT_W    (SHIFT_W),
      .SHIFT_IMPL (SHIFT_IMPL)
   ) u_prod (
      .act_i   (act_i),
      .sign_i  (wsign),
      .shamt_i (shamt),
      .prod_o  (prod)
   );

   pot_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .prod_i  (prod),
      .valid_i (valid_i),
      .clear_i (clear_i),
      .acc_o   (acc_o)
   );

endmodule

// File: tb/pot_shift_mac_tb_top.sv
module pot_shift_mac_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  act = '0;
   logic [3:0]  wcode = '0;
   logic        valid = 1'b0;
   logic        clear = 1'b0;
   logic [31:0] acc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic signed [31:0] model = '0;
   logic signed [31:0] exp_q[$];
   string              tag_q[$];

   always #4 clk = ~clk;

   pot_shift_mac dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .act_i   (act),
      .wcode_i (wcode),
      .valid_i (valid),
      .clear_i (clear),
      .acc_o   (acc)
   );

   function automatic logic signed [31:0] ref_prod(logic [7:0] a, logic [3:0] c);
      logic signed [31:0] w;
      w = 32'sd1 <<< c[2:0];
      if (c[3]) w = -w;
      return $signed({{24{a[7]}}, a}) * w;
   endfunction

   task automatic beat(logic [7:0] a, logic [3:0] c, logic v, logic clr, string tag);
      @(negedge clk);
      act = a; wcode = c; valid = v; clear = clr;
      if (v) model = (clr ? 32'sd0 : model) + ref_prod(a, c);
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   always begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
         logic signed [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ($signed(acc) !== e) begin
            errors++;
            $display("FAIL %s: acc_o=%0d expected %0d", t, $signed(acc), e);
         end
      end
   end

   task automatic direct_check(logic signed [31:0] e, string tag);
      checks++;
      if ($signed(acc) !== e) begin
         errors++;
         $display("FAIL %s: acc_o=%0d expected %0d", tag, $signed(acc), e);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      direct_check(0, "R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      direct_check(0, "R1 after release");

      // R3 / R2: exhaustive products via clear-load
      for (int a = 0; a < 256; a++)
         for (int c = 0; c < 16; c++)
            beat(a[7:0], c[3:0], 1'b1, 1'b1, "R3 exhaustive");

      // R6 corner: -128 with -2^7
      beat(8'h80, 4'hF, 1'b1, 1'b1, "R6 load -128*-128");
      // R2 sign bit: code 4'b1000 is -1
      beat(8'd5, 4'b1000, 1'b1, 1'b1, "R2 sign negative s0");
      // R4 accumulate sequence
      beat(8'd3, 4'b0010, 1'b1, 1'b0, "R4 add 3*4");
      beat(8'hFE, 4'b0011, 1'b1, 1'b0, "R4 add -2*8");
      // R5 idle with garbage, clear high
      beat(8'h7F, 4'b0111, 1'b0, 1'b1, "R5 clear without valid");
      beat(8'h80, 4'b1111, 1'b0, 1'b0, "R5 idle garbage");
      // R7 single-edge latency
      beat(8'd1, 4'b0000, 1'b1, 1'b0, "R7 one-cycle update");
      // R8 cross zero downward then upward
      beat(8'd10, 4'b0000, 1'b1, 1'b1, "R8 load 10");
      beat(8'd100, 4'b1111, 1'b1, 1'b0, "R8 go negative");
      beat(8'd127, 4'b0111, 1'b1, 1'b0, "R8 back positive");
      for (int i = 0; i < 64; i++)
         beat(8'h80, 4'b0111, 1'b1, 1'b0, "R8 long negative run");
      // R6 clear discards long sum
      beat(8'hC3, 4'b1101, 1'b1, 1'b1, "R6 clear discards sum");
      beat(8'h00, 4'b0000, 1'b0, 1'b0, "R5 drain");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule